// File: doc/BRIEF.md
# Register-to-Register ALU Unit

This block runs two-operand arithmetic and logic between registers of a small CPU register file that it owns. An instruction supplies a 3-bit operation select and a postbyte. The postbyte names two registers with 4-bit codes: the upper nibble is the source and the lower nibble is the destination. When `go` is high at a rising clock edge, the block reads both registers, computes the result, writes it to the destination and updates the condition-code register, all at that one edge.

The file holds four 8-bit accumulators. Two of them pair into D and the other two pair into W, and D with W forms a 32-bit view. It also holds five 16-bit pointer registers, a direct-page byte, the condition codes, and a 16-bit value register that reset does not clear. A load port presets registers. A debug port reads any register by its code, and a second output presents the 32-bit view.

Top module: `rr_alu_unit`

## Requirements
- R1: Register codes are D=0000, X=0001, Y=0010, U=0011, S=0100, PC=0101, W=0110, V=0111, A=1000, B=1001, CC=1010, DP=1011, E=1110, F=1111. D reads as {A,B}, W reads as {E,F}, and `q_view` is {A,B,E,F}. Writing D or W updates both halves.
- R2: `op_sel` codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 EOR, 7 CMP. The result is dst OP src, where src is `postbyte[7:4]` and dst is `postbyte[3:0]`, and it is written to dst.
- R3: Codes 0xxx are 16 bits wide and codes 1xxx are 8 bits wide. If either operand is 16-bit, the operation is 16-bit and an 8-bit operand is zero-extended. An 8-bit destination keeps the low byte.
- R4: ADD and ADC (ADC adds CC.C) set C to the carry out of the operation width. V is signed overflow, N is the result msb and Z means the result is zero. CC bit positions are C=0, V=1, Z=2, N=3, and bits 7..4 are kept.
- R5: SUB, SBC and CMP compute dst - src (SBC also subtracts CC.C). C is the borrow, V is signed overflow, and N and Z are set as in R4.
- R6: AND, OR and EOR set N and Z, clear V and leave C unchanged.
- R7: CMP updates the flags and writes no register.
- R8: Codes 1100 and 1101 read as zero, and writes to them are dropped. Flags still update.
- R9: Reset clears every register except V, which keeps its value.
- R10: When a non-compare operation targets CC, the written result replaces CC and the flag update is dropped.
- R11: `ld_en` writes `ld_data` to `ld_sel` with the width rule of R3. When `go` and `ld_en` are both high, the load is ignored.
- R12: Results and flags are visible on `dbg_data` right after the clock edge that samples `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Execute the selected operation this edge |
| op_sel | input | 3 | Operation select (R2) |
| postbyte | input | 8 | Source code [7:4], destination code [3:0] |
| ld_en | input | 1 | Register preset strobe |
| ld_sel | input | 4 | Register code for preset |
| ld_data | input | 16 | Preset value |
| dbg_sel | input | 4 | Register code for debug read |
| dbg_data | output | 16 | Debug read value (8-bit registers zero-extended) |
| q_view | output | 32 | The 32-bit view {A,B,E,F} |

## Verification
The assertions check the following on every cycle:
- V holds unless it is the write target.
- A load to a reserved code disturbs nothing.
- A write to A shows up in the top byte of the 32-bit view.
- Logic operations clear V and keep C.
- A compare leaves the 32-bit view untouched.

Only the bench's scenarios can show the full arithmetic: carries, borrows, overflow at both widths, zero-extension in mixed-width operations, the CC-destination override and V surviving reset. The bench compares these against its own model over directed and random postbytes.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_EOR, OP_CMP
   } rr_op_e;

   localparam logic [3:0] RC_D  = 4'h0;
   localparam logic [3:0] RC_X  = 4'h1;
   localparam logic [3:0] RC_Y  = 4'h2;
   localparam logic [3:0] RC_U  = 4'h3;
   localparam logic [3:0] RC_S  = 4'h4;
   localparam logic [3:0] RC_PC = 4'h5;
   localparam logic [3:0] RC_W  = 4'h6;
   localparam logic [3:0] RC_V  = 4'h7;
   localparam logic [3:0] RC_A  = 4'h8;
   localparam logic [3:0] RC_B  = 4'h9;
   localparam logic [3:0] RC_CC = 4'hA;
   localparam logic [3:0] RC_DP = 4'hB;
   localparam logic [3:0] RC_E  = 4'hE;
   localparam logic [3:0] RC_F  = 4'hF;

   localparam int FLAG_C = 0;
   localparam int FLAG_V = 1;
   localparam int FLAG_Z = 2;
   localparam int FLAG_N = 3;

   function automatic logic code_is_wide(input logic [3:0] c);
      return !c[3];
   endfunction
endpackage

// File: rtl/rr_alu_core.sv
module rr_alu_core
   import rr_alu_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  rr_op_e                  op,
   input  logic                    wide,
   input  logic [2*BYTE_W-1:0]     dst_val,
   input  logic [2*BYTE_W-1:0]     src_val,
   input  logic                    cin,
   output logic [2*BYTE_W-1:0]     res,
   output logic [3:0]              flags
);
   localparam int WORD_W = 2 * BYTE_W;

   logic [WORD_W:0] raw;
   logic [WORD_W:0] cx;
   logic            is_arith, is_sub, r_msb, a_msb, b_msb, carry, ovf;

   always_comb begin
      is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
      is_arith = is_sub || (op == OP_ADD) || (op == OP_ADC);
      cx       = {{WORD_W{1'b0}}, cin && ((op == OP_ADC) || (op == OP_SBC))};
      case (op)
         OP_ADD, OP_ADC: raw = {1'b0, dst_val} + {1'b0, src_val} + cx;
         OP_SUB, OP_SBC,
         OP_CMP:         raw = {1'b0, dst_val} - {1'b0, src_val} - cx;
         OP_AND:         raw = {1'b0, dst_val & src_val};
         OP_OR:          raw = {1'b0, dst_val | src_val};
         default:        raw = {1'b0, dst_val ^ src_val};
      endcase
      res   = wide ? raw[WORD_W-1:0] : {{BYTE_W{1'b0}}, raw[BYTE_W-1:0]};
      carry = wide ? raw[WORD_W] : raw[BYTE_W];
      r_msb = wide ? raw[WORD_W-1] : raw[BYTE_W-1];
      a_msb = wide ? dst_val[WORD_W-1] : dst_val[BYTE_W-1];
      b_msb = wide ? src_val[WORD_W-1] : src_val[BYTE_W-1];
      ovf   = is_sub ? ((a_msb != b_msb) && (r_msb != a_msb))
                     : ((a_msb == b_msb) && (r_msb != a_msb));
      flags[FLAG_N] = r_msb;
      flags[FLAG_Z] = (res == '0);
      flags[FLAG_V] = is_arith && ovf;
      flags[FLAG_C] = is_arith ? carry : cin;
   end
endmodule

// File: rtl/rr_regfile.sv
module rr_regfile
   import rr_alu_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [3:0]            wr_sel,
   input  logic [2*BYTE_W-1:0]   wr_data,
   input  logic                  cc_en,
   input  logic [BYTE_W-1:0]     cc_data,
   input  logic [3:0]            rd_a_sel,
   input  logic [3:0]            rd_b_sel,
   input  logic [3:0]            dbg_sel,
   output logic [2*BYTE_W-1:0]   rd_a,
   output logic [2*BYTE_W-1:0]   rd_b,
   output logic [2*BYTE_W-1:0]   dbg_data,
   output logic [4*BYTE_W-1:0]   q_view,
   output logic [BYTE_W-1:0]     cc_q
);
   localparam int WORD_W = 2 * BYTE_W;
   localparam int NPTR   = 5;
   localparam logic [BYTE_W-1:0] ZB = '0;

   logic [BYTE_W-1:0] a_q, b_q, e_q, f_q, dp_q;
   logic [WORD_W-1:0] v_q;
   logic [WORD_W-1:0] ptr_rd [NPTR];

   for (genvar i = 0; i < NPTR; i++) begin : g_ptr
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                q <= '0;
         else if (wr_en && (wr_sel == 4'(i + 1)))   q <= wr_data;
      end
      assign ptr_rd[i] = q;
   end

   // the value register has no reset on purpose
   always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == RC_V)) v_q <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0; b_q <= '0; e_q <= '0; f_q <= '0; dp_q <= '0; cc_q <= '0;
      end else begin
         if (wr_en && (wr_sel == RC_A))      a_q <= wr_data[BYTE_W-1:0];
         else if (wr_en && (wr_sel == RC_D)) a_q <= wr_data[WORD_W-1:BYTE_W];
         if (wr_en && ((wr_sel == RC_B) || (wr_sel == RC_D))) b_q <= wr_data[BYTE_W-1:0];
         if (wr_en && (wr_sel == RC_E))      e_q <= wr_data[BYTE_W-1:0];
         else if (wr_en && (wr_sel == RC_W)) e_q <= wr_data[WORD_W-1:BYTE_W];
         if (wr_en && ((wr_sel == RC_F) || (wr_sel == RC_W))) f_q <= wr_data[BYTE_W-1:0];
         if (wr_en && (wr_sel == RC_DP))     dp_q <= wr_data[BYTE_W-1:0];
         if (wr_en && (wr_sel == RC_CC))     cc_q <= wr_data[BYTE_W-1:0];
         else if (cc_en)                     cc_q <= cc_data;
      end
   end

   function automatic logic [WORD_W-1:0] rd(input logic [3:0] c);
      case (c)
         RC_D:    return {a_q, b_q};
         RC_X:    return ptr_rd[0];
         RC_Y:    return ptr_rd[1];
         RC_U:    return ptr_rd[2];
         RC_S:    return ptr_rd[3];
         RC_PC:   return ptr_rd[4];
         RC_W:    return {e_q, f_q};
         RC_V:    return v_q;
         RC_A:    return {ZB, a_q};
         RC_B:    return {ZB, b_q};
         RC_CC:   return {ZB, cc_q};
         RC_DP:   return {ZB, dp_q};
         RC_E:    return {ZB, e_q};
         RC_F:    return {ZB, f_q};
         default: return '0;
      endcase
   endfunction

   assign rd_a     = rd(rd_a_sel);
   assign rd_b     = rd(rd_b_sel);
   assign dbg_data = rd(dbg_sel);
   assign q_view   = {a_q, b_q, e_q, f_q};

   assert_v_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel == RC_V)) |=> $stable(v_q));

   assert_reserved_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel[3:1] == 3'b110) && !cc_en) |=>
         ($stable(q_view) && $stable(dp_q) && $stable(cc_q) && $stable(v_q)));

   assert_a_in_d_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == RC_A)) |=> (q_view[4*BYTE_W-1:3*BYTE_W] == $past(wr_data[BYTE_W-1:0])));
endmodule

// File: rtl/rr_alu_unit.sv
module rr_alu_unit
   import rr_alu_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [2:0]            op_sel,
   input  logic [7:0]            postbyte,
   input  logic                  ld_en,
   input  logic [3:0]            ld_sel,
   input  logic [2*BYTE_W-1:0]   ld_data,
   input  logic [3:0]            dbg_sel,
   output logic [2*BYTE_W-1:0]   dbg_data,
   output logic [4*BYTE_W-1:0]   q_view
);
   localparam int WORD_W = 2 * BYTE_W;

   if (BYTE_W < 4) begin : g_bad_width
      $error("rr_alu_unit: BYTE_W must be at least 4");
   end

   rr_op_e            op;
   logic [3:0]        src_c, dst_c;
   logic              wide, is_cmp, dst_is_cc;
   logic [WORD_W-1:0] src_v, dst_v, res;
   logic [3:0]        flags;
   logic [BYTE_W-1:0] cc_q, cc_next;
   logic              wr_en, cc_en;
   logic [3:0]        wr_sel;
   logic [WORD_W-1:0] wr_data;

   assign op        = rr_op_e'(op_sel);
   assign src_c     = postbyte[7:4];
   assign dst_c     = postbyte[3:0];
   assign wide      = code_is_wide(src_c) || code_is_wide(dst_c);
   assign is_cmp    = (op == OP_CMP);
   assign dst_is_cc = (dst_c == RC_CC);

   always_comb begin
      if (go) begin
         wr_en   = !is_cmp;
         wr_sel  = dst_c;
         wr_data = res;
      end else begin
         wr_en   = ld_en;
         wr_sel  = ld_sel;
         wr_data = ld_data;
      end
      cc_en   = go && !(dst_is_cc && !is_cmp);
      cc_next = {cc_q[BYTE_W-1:4], flags};
   end

   rr_regfile #(.BYTE_W(BYTE_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cc_en(cc_en), .cc_data(cc_next),
      .rd_a_sel(dst_c), .rd_b_sel(src_c), .dbg_sel(dbg_sel),
      .rd_a(dst_v), .rd_b(src_v), .dbg_data(dbg_data),
      .q_view(q_view), .cc_q(cc_q)
   );

   rr_alu_core #(.BYTE_W(BYTE_W)) u_core (
      .op(op), .wide(wide), .dst_val(dst_v), .src_val(src_v),
      .cin(cc_q[FLAG_C]), .res(res), .flags(flags)
   );

   assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (go && (op_sel >= 3'd4) && (op_sel != 3'd7) && !dst_is_cc) |=>
         (!cc_q[FLAG_V] && (cc_q[FLAG_C] == $past(cc_q[FLAG_C]))));

   assert_cmp_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && is_cmp) |=> $stable(q_view));
endmodule

// File: tb/sim_rr_alu_unit.sv
`timescale 1ns/1ps
module sim_rr_alu_unit;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        go = 0;
   logic [2:0]  op_sel = 0;
   logic [7:0]  postbyte = 0;
   logic        ld_en = 0;
   logic [3:0]  ld_sel = 0;
   logic [15:0] ld_data = 0;
   logic [3:0]  dbg_sel = 0;
   logic [15:0] dbg_data;
   logic [31:0] q_view;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   // bench model of the register file
   logic [7:0]  ma, mb, me, mf, mdp, mcc;
   logic [15:0] mx, my, mu, ms, mpc, mv;

   rr_alu_unit u0 (.*);

   always #5 clk = ~clk;

   function automatic logic [15:0] mrd(input logic [3:0] c);
      case (c)
         4'h0: return {ma, mb};
         4'h1: return mx;
         4'h2: return my;
         4'h3: return mu;
         4'h4: return ms;
         4'h5: return mpc;
         4'h6: return {me, mf};
         4'h7: return mv;
         4'h8: return {8'h0, ma};
         4'h9: return {8'h0, mb};
         4'hA: return {8'h0, mcc};
         4'hB: return {8'h0, mdp};
         4'hE: return {8'h0, me};
         4'hF: return {8'h0, mf};
         default: return 16'h0;
      endcase
   endfunction

   task automatic mwr(input logic [3:0] c, input logic [15:0] v);
      case (c)
         4'h0: {ma, mb} = v;
         4'h1: mx = v;
         4'h2: my = v;
         4'h3: mu = v;
         4'h4: ms = v;
         4'h5: mpc = v;
         4'h6: {me, mf} = v;
         4'h7: mv = v;
         4'h8: ma = v[7:0];
         4'h9: mb = v[7:0];
         4'hA: mcc = v[7:0];
         4'hB: mdp = v[7:0];
         4'hE: me = v[7:0];
         4'hF: mf = v[7:0];
         default: ;
      endcase
   endtask

   task automatic mreset();
      ma = 0; mb = 0; me = 0; mf = 0; mdp = 0; mcc = 0;
      mx = 0; my = 0; mu = 0; ms = 0; mpc = 0;
   endtask

   task automatic mexec(input logic [2:0] op, input logic [7:0] pb);
      logic [3:0]  s, d;
      logic        wide, c, sub, ar, am, bm, rm, n, z, v, cy;
      logic [15:0] a, b, r;
      logic [16:0] raw;
      int          msb;
      s = pb[7:4]; d = pb[3:0];
      wide = !s[3] || !d[3];
      a = mrd(d); b = mrd(s); c = mcc[0];
      msb = wide ? 15 : 7;
      sub = (op == 2) || (op == 3) || (op == 7);
      ar = sub || (op == 0) || (op == 1);
      case (op)
         0: raw = {1'b0, a} + {1'b0, b};
         1: raw = {1'b0, a} + {1'b0, b} + {16'h0, c};
         2, 7: raw = {1'b0, a} - {1'b0, b};
         3: raw = {1'b0, a} - {1'b0, b} - {16'h0, c};
         4: raw = {1'b0, a & b};
         5: raw = {1'b0, a | b};
         default: raw = {1'b0, a ^ b};
      endcase
      r  = wide ? raw[15:0] : {8'h0, raw[7:0]};
      cy = ar ? (wide ? raw[16] : raw[8]) : c;
      am = a[msb]; bm = b[msb]; rm = r[msb];
      v  = ar && (sub ? ((am != bm) && (rm != am)) : ((am == bm) && (rm != am)));
      n  = rm; z = (r == 0);
      if (d == 4'hA && op != 7) mwr(d, r);
      else begin
         mcc = {mcc[7:4], n, z, v, cy};
         if (op != 7) mwr(d, r);
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rdreg(input logic [3:0] c, output logic [15:0] v);
      dbg_sel = c;
      #1;
      v = dbg_data;
   endtask

   task automatic load(input logic [3:0] c, input logic [15:0] v);
      @(negedge clk);
      ld_en = 1; ld_sel = c; ld_data = v;
      @(negedge clk);
      ld_en = 0;
      mwr(c, v);
   endtask

   task automatic exec(input logic [2:0] op, input logic [7:0] pb);
      @(negedge clk);
      go = 1; op_sel = op; postbyte = pb;
      @(negedge clk);
      go = 0;
      mexec(op, pb);
   endtask

   task automatic sweep(input string req);
      logic [15:0] v;
      for (int i = 0; i < 16; i++) begin
         rdreg(4'(i), v);
         check(req, {16'h0, v}, {16'h0, mrd(4'(i))});
      end
      check(req, q_view, {ma, mb, me, mf});
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd4242));
      mreset();
      mv = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      load(4'h7, 16'h0000);
      // R9 reset state
      sweep("R9 reset state");

      // R1 pairs and views
      load(4'h0, 16'h1234);
      load(4'h6, 16'hABCD);
      rdreg(4'h8, v); check("R1 A half of D", {16'h0, v}, 32'h12);
      rdreg(4'hF, v); check("R1 F half of W", {16'h0, v}, 32'hCD);
      check("R1 q view", q_view, 32'h1234ABCD);

      // R9 V survives reset
      load(4'h7, 16'hBEEF);
      load(4'h1, 16'h5555);
      @(negedge clk); rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
      mreset();
      rdreg(4'h7, v); check("R9 V persists", {16'h0, v}, 32'hBEEF);
      rdreg(4'h1, v); check("R9 X cleared", {16'h0, v}, 32'h0);

      // R4 8-bit signed overflow: A=7F + B=01 -> A=80, N=1 V=1
      load(4'h8, 16'h007F); load(4'h9, 16'h0001);
      exec(3'd0, 8'h98);
      rdreg(4'h8, v); check("R4 add result", {16'h0, v}, 32'h80);
      rdreg(4'hA, v); check("R4 add flags", {28'h0, v[3:0]}, 32'hA);
      // R12 result seen right after the edge
      check("R12 model agrees", {16'h0, v}, {24'h0, mcc});

      // R3 mixed width: A=FF added into X=0001 -> 0100
      load(4'h8, 16'h00FF); load(4'h1, 16'h0001);
      exec(3'd0, 8'h81);
      rdreg(4'h1, v); check("R3 zero-extend", {16'h0, v}, 32'h0100);
      rdreg(4'hA, v); check("R3 16-bit flags", {28'h0, v[3:0]}, 32'h0);

      // R5 borrow: B=01 - A=02 into B
      load(4'h8, 16'h0002); load(4'h9, 16'h0001);
      exec(3'd2, 8'h89);
      rdreg(4'h9, v); check("R5 sub result", {16'h0, v}, 32'hFF);
      rdreg(4'hA, v); check("R5 sub flags", {28'h0, v[3:0]}, 32'h9);
      // R2 SBC uses carry: 0x10 - 0x01 - C(1) = 0x0E
      load(4'h8, 16'h0001); load(4'h9, 16'h0010);
      exec(3'd3, 8'h89);
      rdreg(4'h9, v); check("R2 sbc with carry", {16'h0, v}, 32'h0E);

      // R6 logic keeps C: set C, then AND
      load(4'hA, 16'h0001);
      load(4'hE, 16'h00F0); load(4'hF, 16'h000F);
      exec(3'd4, 8'hEF);
      rdreg(4'hF, v); check("R6 and result", {16'h0, v}, 32'h0);
      rdreg(4'hA, v); check("R6 and flags", {28'h0, v[3:0]}, 32'h5);

      // R7 compare writes nothing
      load(4'h2, 16'h1000); load(4'h3, 16'h1000);
      exec(3'd7, 8'h23);
      rdreg(4'h3, v); check("R7 cmp dest kept", {16'h0, v}, 32'h1000);
      rdreg(4'hA, v); check("R7 cmp Z set", {28'h0, v[3:0]}, {28'h0, mcc[3:0]});

      // R8 reserved dest and source
      exec(3'd0, 8'h1C);
      rdreg(4'hC, v); check("R8 reserved reads zero", {16'h0, v}, 32'h0);
      load(4'hD, 16'hFFFF);
      sweep("R8 reserved load dropped");

      // R10 CC as destination: 0x30 OR 0x00 written to CC
      load(4'hB, 16'h0030); load(4'hA, 16'h0000);
      exec(3'd5, 8'hBA);
      rdreg(4'hA, v); check("R10 cc written", {16'h0, v}, 32'h30);

      // R11 go wins over load
      @(negedge clk);
      go = 1; op_sel = 3'd7; postbyte = 8'h12;
      ld_en = 1; ld_sel = 4'h4; ld_data = 16'h7777;
      @(negedge clk);
      go = 0; ld_en = 0;
      mexec(3'd7, 8'h12);
      rdreg(4'h4, v); check("R11 load ignored", {16'h0, v}, {16'h0, ms});

      // random mix
      for (int k = 0; k < 400; k++) begin
         logic [2:0] op;
         logic [7:0] pb;
         if (k % 50 == 0) begin
            for (int i = 0; i < 16; i++) load(4'(i), 16'($urandom));
         end
         op = 3'($urandom);
         pb = 8'($urandom);
         exec(op, pb);
         rdreg(pb[3:0], v);
         check("R2 random dest", {16'h0, v}, {16'h0, mrd(pb[3:0])});
         rdreg(4'hA, v);
         check(op >= 3'd4 && op != 3'd7 ? "R6 random flags" : "R4 R5 random flags",
               {16'h0, v}, {24'h0, mcc});
         if (k % 100 == 99) sweep("R1 random sweep");
      end

      done = 1;
      summary();
      $finish;
   end
endmodule